// File: doc/BRIEF.md
# GPIO Function-Select and Output Core

This core controls 54 general-purpose pins through a 32-bit register bus. Each pin has a 3-bit function field. The field makes the pin an input, a driven output, or hands it to one of six alternate peripherals through an external multiplexer. Ten fields are packed into each select word.

The output latch is never rewritten as a whole word. It changes only through two write-only register pairs. One pair sets latch bits, the other clears them, and a zero bit in the written data leaves that pin alone. A read-only register pair returns the pin inputs after a two-flop synchronizer.

Software that moves a pin from one non-input function to another passes through the input code first. The core takes such writes on consecutive cycles without glitching the output enable.

Top module: `gpio_fnmux_core`

## Requirements
- R1: While reset is low and on the first cycle after it, every function field is 0 (input), `pad_oe` and `pad_out` are all zero, every `alt_sel` entry is 7, and `bus_rdata` is zero.
- R2: The field of pin p lives in the select word at byte offset 4*(p/10) (offsets 0x00 to 0x14), at bits (p mod 10)*3 upward. A read returns the stored fields. Bits 30 and 31, and fields for pins above 53, read as zero and ignore writes.
- R3: Code 1 drives `pad_oe` high. Alternate codes map to alternate index 0..5 on that pin's 3-bit `alt_sel` slot: 4 gives 0, 5 gives 1, 6 gives 2, 7 gives 3, 3 gives 4 and 2 gives 5. Codes 0 and 1 put 7 (no alternate) on `alt_sel`. `pad_oe` is low for every code other than 1.
- R4: A write to the set words (0x1C for pins 0-31, 0x20 for pins 32-53, pin p at bit p mod 32) sets the latch bit of each pin whose data bit is 1. A write to the clear words (0x28 and 0x2C, same bit layout) clears them. Zero data bits leave the latch unchanged. `pad_out` shows the latch.
- R5: Set and clear words read as zero. Data bits for pins above 53 in the second set or clear word change nothing.
- R6: Level words at 0x34 (pins 0-31) and 0x38 (pins 32-53, bits above 21 zero) return `pad_in` through two synchronizing flops. A change on `pad_in` is first visible in read data captured on the third rising edge after the change.
- R7: `bus_rdata` loads on the rising edge at which `bus_rd` is high and holds otherwise. Addresses that map to no register read as zero.
- R8: `pad_oe`, `pad_out` and `alt_sel` change only on the edge that takes a write, and on that same edge as the stored field. A move between two alternate codes by way of the input code on consecutive write cycles never raises `pad_oe`.
- R9: The output latch is independent of the function field. A latch value set while the pin is not an output is kept, and appears with `pad_oe` when the pin returns to code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; data follows on the next cycle |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 54 | Asynchronous pin levels from the pads |
| pad_oe | output | 54 | Per-pin output enable (high only for code 1) |
| pad_out | output | 54 | Per-pin output latch value |
| alt_sel | output | 162 | Per-pin 3-bit alternate index, pin p at bits 3p+2..3p; 7 means no alternate |

## Verification
Assertions check five properties on every cycle:
- An enabled output never carries an alternate index.
- All pin outputs are stable across cycles without a write.
- Read data holds when no read is issued.
- Set and clear words read as zero.
- The unpopulated top bits of the second level word read as zero.

The remaining behaviours are left to the bench's scenarios:
- the code-to-alternate mapping and the packing of ten fields per word, checked with a sweep of every code through every slot;
- the latch arithmetic under mixed set and clear patterns;
- the exact two-stage input latency;
- the absence of an output-enable pulse during a move through the input code.

// File: rtl/gpio_fnmux_pkg.sv
`timescale 1ns/1ps
// Package: shared codes and types for the GPIO function-select core.
// Assumes a 3-bit function field and at most 16 words per register group.
package gpio_fnmux_pkg;

    localparam int FN_W  = 3;
    localparam int IDX_W = 4;

    // Function field codes; the order of the alternates is not sequential.
    typedef enum logic [FN_W-1:0] {
        FN_IN   = 3'd0,
        FN_OUT  = 3'd1,
        FN_ALT5 = 3'd2,
        FN_ALT4 = 3'd3,
        FN_ALT0 = 3'd4,
        FN_ALT1 = 3'd5,
        FN_ALT2 = 3'd6,
        FN_ALT3 = 3'd7
    } fn_code_e;

    localparam logic [FN_W-1:0] ALT_NONE = 3'd7;

    typedef enum logic [2:0] {
        RK_NONE = 3'd0,
        RK_SEL  = 3'd1,
        RK_SET  = 3'd2,
        RK_CLR  = 3'd3,
        RK_LEV  = 3'd4
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_hit_t;

    // Map a function code to the index the external mux expects.
    function automatic logic [FN_W-1:0] alt_of(input logic [FN_W-1:0] code);
        case (code)
            FN_ALT0: alt_of = 3'd0;
            FN_ALT1: alt_of = 3'd1;
            FN_ALT2: alt_of = 3'd2;
            FN_ALT3: alt_of = 3'd3;
            FN_ALT4: alt_of = 3'd4;
            FN_ALT5: alt_of = 3'd5;
            default: alt_of = ALT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_fnmux_decode.sv
`timescale 1ns/1ps
// Module: address decoder. Turns a byte address into a register group and a
// word index within it. Assumes word-aligned accesses (low two bits ignored)
// and groups that do not overlap.
module gpio_fnmux_decode
    import gpio_fnmux_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SEL_WORDS = 6,
    parameter int BANKS     = 2,
    parameter int SEL_BASE  = 'h00,
    parameter int SET_BASE  = 'h1C,
    parameter int CLR_BASE  = 'h28,
    parameter int LEV_BASE  = 'h34
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit
);
    localparam int SEL_W0 = SEL_BASE / 4;
    localparam int SET_W0 = SET_BASE / 4;
    localparam int CLR_W0 = CLR_BASE / 4;
    localparam int LEV_W0 = LEV_BASE / 4;

    int   wi;
    logic unused_lsb;

    assign wi         = int'(addr[ADDR_W-1:2]);
    assign unused_lsb = ^addr[1:0];

    // Purpose: find which register group and word the address falls in.
    always_comb begin
        hit.kind = RK_NONE;
        hit.idx  = '0;
        if (wi >= SEL_W0 && wi < SEL_W0 + SEL_WORDS) begin
            hit.kind = RK_SEL;
            hit.idx  = IDX_W'(wi - SEL_W0);
        end else if (wi >= SET_W0 && wi < SET_W0 + BANKS) begin
            hit.kind = RK_SET;
            hit.idx  = IDX_W'(wi - SET_W0);
        end else if (wi >= CLR_W0 && wi < CLR_W0 + BANKS) begin
            hit.kind = RK_CLR;
            hit.idx  = IDX_W'(wi - CLR_W0);
        end else if (wi >= LEV_W0 && wi < LEV_W0 + BANKS) begin
            hit.kind = RK_LEV;
            hit.idx  = IDX_W'(wi - LEV_W0);
        end
    end

endmodule

// File: rtl/gpio_fnmux_fnsel.sv
`timescale 1ns/1ps
// Module: per-pin function fields. Registers the field together with the
// decoded output enable and alternate index. All three come from the same
// next-state value, so they move on one edge and carry no decode hazard.
// Assumes PER_WORD*FN_W <= DATA_W.
module gpio_fnmux_fnsel
    import gpio_fnmux_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int PER_WORD = 10,
    parameter int DATA_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [NUM_PINS*FN_W-1:0] fn_flat,
    output logic [NUM_PINS-1:0]      oe,
    output logic [NUM_PINS*FN_W-1:0] alt_flat
);
    logic unused_wd;
    assign unused_wd = ^wdata;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int WI = p / PER_WORD;
        localparam int SH = (p % PER_WORD) * FN_W;

        logic            hit;
        logic [FN_W-1:0] fn_d, fn_q, alt_q;
        logic            oe_q;

        assign hit  = wr_en && (wr_idx == IDX_W'(WI));
        assign fn_d = hit ? wdata[SH +: FN_W] : fn_q;

        // Purpose: hold the field and its registered decodes for this pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fn_q  <= FN_IN;
                oe_q  <= 1'b0;
                alt_q <= ALT_NONE;
            end else begin
                fn_q  <= fn_d;
                oe_q  <= (fn_d == FN_OUT);
                alt_q <= alt_of(fn_d);
            end
        end

        assign fn_flat[p*FN_W +: FN_W]  = fn_q;
        assign alt_flat[p*FN_W +: FN_W] = alt_q;
        assign oe[p]                    = oe_q;
    end

endmodule

// File: rtl/gpio_fnmux_outlatch.sv
`timescale 1ns/1ps
// Module: output latch with write-one-to-set and write-one-to-clear words.
// Pin p is bit p mod DATA_W of bank p / DATA_W. Assumes that one write
// cycle addresses either the set group or the clear group, not both.
module gpio_fnmux_outlatch
    import gpio_fnmux_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_PINS-1:0] latch
);
    logic unused_wd;
    assign unused_wd = ^wdata;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int BK = p / DATA_W;
        localparam int BT = p % DATA_W;

        logic sel, q;
        assign sel = (idx == IDX_W'(BK)) && wdata[BT];

        // Purpose: set or clear this pin's latch bit on a matching one bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= 1'b0;
            else if (set_en && sel)
                q <= 1'b1;
            else if (clr_en && sel)
                q <= 1'b0;
        end

        assign latch[p] = q;
    end

endmodule

// File: rtl/gpio_fnmux_sync.sv
`timescale 1ns/1ps
// Module: multi-flop synchronizer for the asynchronous pin inputs.
// Assumes each pin is independent, with no cross-pin coherence.
module gpio_fnmux_sync #(
    parameter int NUM_PINS = 54,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] d,
    output logic [NUM_PINS-1:0] q
);
    logic [NUM_PINS-1:0] stage_q [STAGES];

    // Purpose: shift the pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_fnmux_core.sv
`timescale 1ns/1ps
// Module: top of the GPIO function-select and output core.
// Decodes the register bus, steers writes to the field store or the latch,
// and returns registered read data one cycle after a read strobe.
// Assumes at most one access per cycle, and word-aligned addresses.
module gpio_fnmux_core
    import gpio_fnmux_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int PER_WORD = 10,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int SYNC_STG = 2,
    parameter int SEL_BASE = 'h00,
    parameter int SET_BASE = 'h1C,
    parameter int CLR_BASE = 'h28,
    parameter int LEV_BASE = 'h34
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_PINS-1:0]      pad_in,
    output logic [NUM_PINS-1:0]      pad_oe,
    output logic [NUM_PINS-1:0]      pad_out,
    output logic [NUM_PINS*FN_W-1:0] alt_sel
);
    localparam int SEL_WORDS = (NUM_PINS + PER_WORD - 1) / PER_WORD;
    localparam int BANKS     = (NUM_PINS + DATA_W - 1) / DATA_W;
    localparam int SEL_SPAN  = PER_WORD * FN_W;
    localparam int SEL_BITS  = SEL_WORDS * SEL_SPAN;
    localparam int LEV_BITS  = BANKS * DATA_W;

    reg_hit_t                 hit;
    logic                     sel_wr, set_wr, clr_wr;
    logic [NUM_PINS*FN_W-1:0] fn_flat;
    logic [SEL_BITS-1:0]      fn_pad;
    logic [NUM_PINS-1:0]      lev_sync;
    logic [LEV_BITS-1:0]      lev_pad;
    logic [DATA_W-1:0]        rd_next, rdata_q;

    gpio_fnmux_decode #(
        .ADDR_W(ADDR_W), .SEL_WORDS(SEL_WORDS), .BANKS(BANKS),
        .SEL_BASE(SEL_BASE), .SET_BASE(SET_BASE),
        .CLR_BASE(CLR_BASE), .LEV_BASE(LEV_BASE)
    ) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    assign sel_wr = bus_wr && (hit.kind == RK_SEL);
    assign set_wr = bus_wr && (hit.kind == RK_SET);
    assign clr_wr = bus_wr && (hit.kind == RK_CLR);

    gpio_fnmux_fnsel #(
        .NUM_PINS(NUM_PINS), .PER_WORD(PER_WORD), .DATA_W(DATA_W)
    ) u_fn (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sel_wr),
        .wr_idx   (hit.idx),
        .wdata    (bus_wdata),
        .fn_flat  (fn_flat),
        .oe       (pad_oe),
        .alt_flat (alt_sel)
    );

    gpio_fnmux_outlatch #(
        .NUM_PINS(NUM_PINS), .DATA_W(DATA_W)
    ) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (set_wr),
        .clr_en (clr_wr),
        .idx    (hit.idx),
        .wdata  (bus_wdata),
        .latch  (pad_out)
    );

    gpio_fnmux_sync #(
        .NUM_PINS(NUM_PINS), .STAGES(SYNC_STG)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (lev_sync)
    );

    assign fn_pad  = SEL_BITS'(fn_flat);
    assign lev_pad = LEV_BITS'(lev_sync);

    // Purpose: choose the word a read returns; everything unmapped is zero.
    always_comb begin
        rd_next = '0;
        case (hit.kind)
            RK_SEL: begin
                for (int w = 0; w < SEL_WORDS; w++)
                    if (hit.idx == IDX_W'(w))
                        rd_next = DATA_W'(fn_pad[w*SEL_SPAN +: SEL_SPAN]);
            end
            RK_LEV: begin
                for (int b = 0; b < BANKS; b++)
                    if (hit.idx == IDX_W'(b))
                        rd_next = lev_pad[b*DATA_W +: DATA_W];
            end
            default: rd_next = '0;
        endcase
    end

    // Purpose: register read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_next;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/gpio_fnmux_chk.sv
`timescale 1ns/1ps
// Module: protocol checker bound to gpio_fnmux_core. Observes ports only.
module gpio_fnmux_chk
    import gpio_fnmux_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int SET_BASE = 'h1C,
    parameter int CLR_BASE = 'h28,
    parameter int LEV_BASE = 'h34
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic [NUM_PINS-1:0]      pad_oe,
    input logic [NUM_PINS-1:0]      pad_out,
    input logic [NUM_PINS*FN_W-1:0] alt_sel
);
    localparam int BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
    localparam int SPARE = BANKS * DATA_W - NUM_PINS;

    int   wa;
    logic rd_setclr, rd_levtop, unused_lsb;

    assign wa         = int'(bus_addr[ADDR_W-1:2]);
    assign unused_lsb = ^bus_addr[1:0];
    assign rd_setclr  = bus_rd &&
                        ((wa >= SET_BASE/4 && wa < SET_BASE/4 + BANKS) ||
                         (wa >= CLR_BASE/4 && wa < CLR_BASE/4 + BANKS));
    assign rd_levtop  = bus_rd && (wa == LEV_BASE/4 + BANKS - 1);

    // R1
    reset_clears_outputs_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

    // R8
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pad_oe) && $stable(pad_out) && $stable(alt_sel)));

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R5
    setclr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_setclr |=> (bus_rdata == '0));

    if (SPARE > 0) begin : g_spare
        // R6
        lev_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_levtop |=> (bus_rdata[DATA_W-1:DATA_W-SPARE] == '0));
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // R3
        oe_excludes_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[p] |-> (alt_sel[p*FN_W +: FN_W] == ALT_NONE));
    end

endmodule

bind gpio_fnmux_core gpio_fnmux_chk #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE), .LEV_BASE(LEV_BASE)
) u_chk (.*);

// File: tb/sim_gpio_fnmux_core.sv
`timescale 1ns/1ps
module sim_gpio_fnmux_core;
    localparam int NP = 54;
    localparam int PW = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [NP-1:0]   pad_in = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pad_oe, pad_out;
    logic [NP*3-1:0] alt_sel;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [2:0]    fn_m [NP];
    logic [NP-1:0] out_m = '0;
    bit   watch = 0;
    bit   oe_seen = 0;

    gpio_fnmux_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .alt_sel(alt_sel)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (watch && pad_oe[3]) oe_seen = 1;

    task automatic chk(input bit ok, input string tag,
                       input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    function automatic logic [2:0] exp_alt(input logic [2:0] c);
        if (c >= 3'd4)      return c - 3'd4;
        else if (c >= 3'd2) return 3'd7 - c;
        else                return 3'd7;
    endfunction

    function automatic logic [31:0] pack_word(input int w);
        logic [31:0] d = '0;
        for (int s = 0; s < PW; s++)
            if (w*PW + s < NP) d[s*3 +: 3] = fn_m[w*PW + s];
        return d;
    endfunction

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++) v[p] = (fn_m[p] == 3'd1);
        return v;
    endfunction

    function automatic logic [NP*3-1:0] exp_alts();
        logic [NP*3-1:0] v;
        for (int p = 0; p < NP; p++) v[p*3 +: 3] = exp_alt(fn_m[p]);
        return v;
    endfunction

    task automatic sel_write(input int w, input logic [31:0] d);
        wr(8'(w*4), d);
        for (int s = 0; s < PW; s++)
            if (w*PW + s < NP) fn_m[w*PW + s] = d[s*3 +: 3];
    endtask

    task automatic pin_fn(input int p, input logic [2:0] c);
        logic [31:0] d = pack_word(p / PW);
        d[(p % PW)*3 +: 3] = c;
        sel_write(p / PW, d);
    endtask

    task automatic latch_op(input bit set, input int b, input logic [31:0] d);
        wr(set ? 8'(8'h1C + b*4) : 8'(8'h28 + b*4), d);
        for (int k = 0; k < 32; k++)
            if (b*32 + k < NP && d[k]) out_m[b*32 + k] = set;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0]   d, e;
        logic [63:0]   lev;
        logic [NP-1:0] oe_snap, out_snap;

        for (int p = 0; p < NP; p++) fn_m[p] = 3'd0;
        repeat (3) @(negedge clk);
        // R1: state while held in reset
        chk(pad_oe == '0 && pad_out == '0 && bus_rdata == '0,
            "R1 in reset", {pad_oe, pad_out}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(alt_sel == exp_alts(), "R1 alt_sel after reset", alt_sel, exp_alts());
        rd(8'h14, d);
        chk(d == 32'h0, "R1 select word 5 after reset", d, 0);

        // R2 R3: every code through every slot of every select word
        for (int w = 0; w < 6; w++) begin
            for (int c = 0; c < 8; c++) begin
                d = 32'hC000_0000;
                for (int s = 0; s < PW; s++) d[s*3 +: 3] = 3'((c + s*3 + w) % 8);
                if (w == 5) d[31:12] = '1;
                sel_write(w, d);
                rd(8'(w*4), e);
                chk(e == pack_word(w), "R2 select readback", e, pack_word(w));
                chk(pad_oe == exp_oe(), "R3 output enable", pad_oe, exp_oe());
                chk(alt_sel == exp_alts(), "R3 alternate index", alt_sel, exp_alts());
            end
        end

        // R8: alt0 -> input -> alt1 on consecutive writes, OE must stay low
        pin_fn(3, 3'd4);
        watch = 1; oe_seen = 0;
        pin_fn(3, 3'd0);
        pin_fn(3, 3'd5);
        @(negedge clk);
        watch = 0;
        chk(!oe_seen, "R8 no OE pulse through input", oe_seen, 0);
        chk(alt_sel[9 +: 3] == 3'd1, "R8 final alternate index", alt_sel[9 +: 3], 1);

        // R8: reads leave the outputs untouched
        oe_snap = pad_oe; out_snap = pad_out;
        rd(8'h00, d); rd(8'h34, d); rd(8'h1C, d);
        chk(pad_oe == oe_snap && pad_out == out_snap, "R8 reads do not disturb",
            {pad_oe, pad_out}, {oe_snap, out_snap});

        // R4: all pins to output, then mixed set/clear patterns
        for (int w = 0; w < 6; w++) sel_write(w, 32'h0924_9249);
        chk(pad_oe == {NP{1'b1}}, "R3 all pins output", pad_oe, {NP{1'b1}});
        for (int i = 0; i < 16; i++) begin
            d = (32'h9E37_79B9 * (i + 1)) ^ (i << 5);
            latch_op(((i / 2) % 2) == 0, i % 2, d);
            chk(pad_out == out_m, "R4 latch set/clear", pad_out, out_m);
        end
        latch_op(1'b1, 1, 32'hFFFF_FFFF);
        chk(pad_out == out_m, "R5 set bank 1 with spare bits", pad_out, out_m);
        latch_op(1'b0, 0, 32'h0000_0000);
        chk(pad_out == out_m, "R4 zero bits leave latch", pad_out, out_m);

        // R5: set and clear words read as zero
        for (int a = 0; a < 4; a++) begin
            rd(8'(8'h1C + (a / 2)*12 + (a % 2)*4), d);
            chk(d == 32'h0, "R5 set/clear read zero", d, 0);
        end

        // R9: latch kept while the pin is an alternate
        latch_op(1'b1, 0, 32'h0000_0020);
        pin_fn(5, 3'd7);
        chk(!pad_oe[5] && pad_out[5] && alt_sel[15 +: 3] == 3'd3,
            "R9 latch kept in alternate", {pad_oe[5], pad_out[5], alt_sel[15 +: 3]}, 5'b01011);
        latch_op(1'b0, 0, 32'h0000_0020);
        chk(pad_out[5] == 1'b0, "R9 clear while alternate", pad_out[5], 0);
        pin_fn(5, 3'd1);
        chk(pad_oe[5] && !pad_out[5], "R9 back to output", {pad_oe[5], pad_out[5]}, 2'b10);

        // R6: level words through the synchronizer
        for (int i = 0; i < 6; i++) begin
            pad_in = NP'({32'h5A5A_0000 + 32'(i*7919), 32'hC3A5_0F00 ^ 32'(i*104729)});
            repeat (3) @(negedge clk);
            lev = 64'(pad_in);
            rd(8'h34, d);
            chk(d == lev[31:0], "R6 level word 0", d, lev[31:0]);
            rd(8'h38, d);
            chk(d == lev[63:32], "R6 level word 1", d, lev[63:32]);
        end

        // R6: two-stage latency with the read strobe held high
        pad_in = '0;
        repeat (3) @(negedge clk);
        pad_in = {NP{1'b1}}; bus_addr = 8'h34; bus_rd = 1'b1;
        @(negedge clk);
        chk(bus_rdata == 32'h0, "R6 latency edge 1", bus_rdata, 0);
        @(negedge clk);
        chk(bus_rdata == 32'h0, "R6 latency edge 2", bus_rdata, 0);
        @(negedge clk);
        chk(bus_rdata == 32'hFFFF_FFFF, "R6 latency edge 3", bus_rdata, 32'hFFFF_FFFF);
        bus_rd = 1'b0;

        // R7: unmapped addresses and hold without a read
        for (int i = 0; i < 5; i++) begin
            case (i)
                0: e = 32'h18;
                1: e = 32'h24;
                2: e = 32'h30;
                3: e = 32'h3C;
                default: e = 32'hFC;
            endcase
            rd(e[7:0], d);
            chk(d == 32'h0, "R7 unmapped reads zero", d, 0);
        end
        rd(8'h38, d);
        chk(d == 32'h003F_FFFF, "R6 spare bits zero", d, 32'h003F_FFFF);
        pad_in = '0;
        repeat (4) @(negedge clk);
        chk(bus_rdata == 32'h003F_FFFF, "R7 rdata holds", bus_rdata, 32'h003F_FFFF);

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule